// File: doc/BRIEF.md
# Edge-Counting Clock Divider Channel

This block is one timer channel that divides an external, asynchronous input signal. Edges of that input are brought into the clock domain and detected. Each selected edge steps a 16-bit down-counter while the channel runs. A counted edge that finds the counter at zero reloads it from a programmable reload register, toggles the divided output and raises a one-cycle interrupt pulse. A reload value of N therefore toggles the output every N+1 counted edges, which gives an output period of 2×(N+1) edges.

Software controls the channel through a small register port. The control register carries self-clearing start and stop trigger bits, a start-interrupt mode bit and a 2-bit edge select. The reload register can be written at any moment. A read-only status register reports whether the channel runs, and the live counter can be read at any time. The channel sequencer has two states, ST_STOPPED and ST_RUNNING, and moves between them through these transitions: START (ST_STOPPED to ST_RUNNING), STOP (ST_RUNNING to ST_STOPPED), RESTART (ST_RUNNING to ST_RUNNING with a reload), COUNT (a decrement in ST_RUNNING) and WRAP (a reload at zero in ST_RUNNING). In ST_STOPPED, edges and a stop write have no effect.

Register map (word address on `reg_addr`). At 0 is the control register: bit 0 is the start trigger, bit 1 the stop trigger, bit 2 the start-interrupt mode, and bits 4:3 the edge select (00 none, 01 rising, 10 falling, 11 both). At 1 is the reload register. At 2 is the status register, with bit 0 set while running. At 3 is the live counter, which is read-only.

Top module: `chdiv_top`

## Requirements
- R1: After reset the counter reads 0, `tout` is 0, `irq` is 0 and status bit 0 is 0.
- R2: Writing control bit 0 = 1 (with bit 1 = 0) sets status bit 0 and loads the counter with the reload register in the next cycle. Control bits 1:0 always read back as 0.
- R3: If control bit 2 is 1 in the write that starts the channel, `irq` pulses for one cycle and `tout` toggles at the start. If the bit is 0, neither happens.
- R4: While running, each edge of `ext_in` that matches control bits 4:3 (01 rising, 10 falling, 11 both, 00 none) decrements a non-zero counter by exactly one. Other edges do nothing.
- R5: A counted edge that finds the counter at 0 reloads it from the reload register, pulses `irq` for exactly one cycle and toggles `tout`.
- R6: Writing the reload register never changes the counter directly. The new value is used at the next start or reload.
- R7: The counter reads correctly at address 3 whether the channel is running or stopped.
- R8: Writing control bit 1 = 1 clears status bit 0. While stopped, the counter and `tout` hold their values and input edges are ignored.
- R9: A control write with both bit 0 and bit 1 set acts as a stop.
- R10: With reload value N, `tout` toggles once every N+1 counted edges.
- R11: A start write while running restarts the count from the reload register without leaving the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ext_in | input | 1 | External signal whose edges are counted (asynchronous) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| tout | output | 1 | Divided output, toggled on each reload |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach from the ports is a counted edge that meets the zero-to-reload wrap while software changes something at nearly the same time: a new reload value, a restart, a stop, or a change of edge polarity. The bench keeps a register-level model of the channel. It first drives directed sequences that walk the counter onto zero and then rewrite the reload register or stop. After that it runs a fixed-seed random mix of input toggles, small reload values, start, stop and combined start-stop writes, and edge-select changes. The small reload values make wraps frequent, so these collisions occur many times.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_RELOAD = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_COUNT  = 2'd3;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_STOP_BIT  = 1;
    localparam int CTRL_MODE_BIT  = 2;
    localparam int CTRL_SEL_LSB   = 3;

    typedef enum logic [1:0] {
        EDGE_NONE    = 2'b00,
        EDGE_RISING  = 2'b01,
        EDGE_FALLING = 2'b10,
        EDGE_BOTH    = 2'b11
    } edge_sel_e;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } chan_state_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_START,
        ACT_RESTART,
        ACT_STOP,
        ACT_COUNT,
        ACT_WRAP
    } chan_act_e;

endpackage

// File: rtl/chdiv_edge_det.sv
module chdiv_edge_det
    import chdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_async,
    input  edge_sel_e sel,
    output logic      edge_hit
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise_w;
    logic                   fall_w;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sig_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise_w =  sync_q[SYNC_STAGES-1] & ~last_q;
    assign fall_w = ~sync_q[SYNC_STAGES-1] &  last_q;

    always_comb begin
        unique case (sel)
            EDGE_NONE:    edge_hit = 1'b0;
            EDGE_RISING:  edge_hit = rise_w;
            EDGE_FALLING: edge_hit = fall_w;
            EDGE_BOTH:    edge_hit = rise_w | fall_w;
            default:      edge_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/chdiv_regs.sv
module chdiv_regs
    import chdiv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              running,
    output logic [CNT_W-1:0]  reload,
    output edge_sel_e         sel,
    output logic              start_p,
    output logic              stop_p,
    output logic              start_irq
);

    logic      ctrl_wr;
    logic      mode_q;
    edge_sel_e sel_q;
    logic [CNT_W-1:0] reload_q;

    assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
    assign start_p = ctrl_wr && wdata[CTRL_START_BIT];
    assign stop_p  = ctrl_wr && wdata[CTRL_STOP_BIT];
    // the mode bit written together with a start governs that start
    assign start_irq = ctrl_wr ? wdata[CTRL_MODE_BIT] : mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            sel_q    <= EDGE_NONE;
            reload_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_CTRL: begin
                    mode_q <= wdata[CTRL_MODE_BIT];
                    sel_q  <= edge_sel_e'(wdata[CTRL_SEL_LSB +: 2]);
                end
                ADDR_RELOAD: reload_q <= wdata;
                default: ;
            endcase
        end
    end

    assign reload = reload_q;
    assign sel    = sel_q;

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rdata[CTRL_MODE_BIT]         = mode_q;
                rdata[CTRL_SEL_LSB +: 2]     = sel_q;
            end
            ADDR_RELOAD: rdata    = reload_q;
            ADDR_STATUS: rdata[0] = running;
            ADDR_COUNT:  rdata    = cnt;
            default:     rdata    = '0;
        endcase
    end

endmodule

// File: rtl/chdiv_fsm.sv
module chdiv_fsm
    import chdiv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_p,
    input  logic             stop_p,
    input  logic             start_irq,
    input  logic             edge_hit,
    input  logic [CNT_W-1:0] reload,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             tout,
    output logic             irq
);

    chan_state_e state_q, state_d;
    chan_act_e   act;
    logic [CNT_W-1:0] cnt_q;
    logic             tout_q;
    logic             irq_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);

    // transition selection: stop has priority over start
    always_comb begin
        state_d = state_q;
        act     = ACT_HOLD;
        unique case (state_q)
            ST_STOPPED: begin
                if (!stop_p && start_p) begin
                    state_d = ST_RUNNING;
                    act     = ACT_START;
                end
            end
            ST_RUNNING: begin
                if (stop_p) begin
                    state_d = ST_STOPPED;
                    act     = ACT_STOP;
                end else if (start_p) begin
                    act = ACT_RESTART;
                end else if (edge_hit) begin
                    act = at_zero ? ACT_WRAP : ACT_COUNT;
                end
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tout_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (act)
                ACT_START, ACT_RESTART: begin
                    cnt_q <= reload;
                    if (start_irq) begin
                        irq_q  <= 1'b1;
                        tout_q <= ~tout_q;
                    end
                end
                ACT_WRAP: begin
                    cnt_q  <= reload;
                    irq_q  <= 1'b1;
                    tout_q <= ~tout_q;
                end
                ACT_COUNT: cnt_q <= cnt_q - 1'b1;
                ACT_STOP, ACT_HOLD: ;
                default: ;
            endcase
        end
    end

    assign running = (state_q == ST_RUNNING);
    assign cnt     = cnt_q;
    assign tout    = tout_q;
    assign irq     = irq_q;

endmodule

// File: rtl/chdiv_top.sv
module chdiv_top
    import chdiv_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_in,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              tout,
    output logic              irq
);

    logic             edge_w;
    logic             start_w;
    logic             stop_w;
    logic             start_irq_w;
    logic             run_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] reload_w;
    edge_sel_e        sel_w;

    chdiv_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_async (ext_in),
        .sel       (sel_w),
        .edge_hit  (edge_w)
    );

    chdiv_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .cnt       (cnt_w),
        .running   (run_w),
        .reload    (reload_w),
        .sel       (sel_w),
        .start_p   (start_w),
        .stop_p    (stop_w),
        .start_irq (start_irq_w)
    );

    chdiv_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_p   (start_w),
        .stop_p    (stop_w),
        .start_irq (start_irq_w),
        .edge_hit  (edge_w),
        .reload    (reload_w),
        .running   (run_w),
        .cnt       (cnt_w),
        .tout      (tout),
        .irq       (irq)
    );

endmodule

// File: rtl/chdiv_chk.sv
module chdiv_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             tout,
    input logic             irq,
    input logic             edge_p,
    input logic             start_p,
    input logic             stop_p
);

    // R5/R3: every interrupt pulse comes with a toggle of the output and vice versa
    assert_irq_with_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (tout != $past(tout)));

    // R8: stopped channel holds counter and output
    assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> ($stable(cnt) && $stable(tout)));

    // R9: stop wins over start
    assert_stop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !run);

    // R2: start loads the reload value and sets running
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p && !stop_p) |=> (run && cnt == $past(reload)));

    // R4: a counted edge on a non-zero counter decrements by one
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && edge_p && cnt != '0 && !start_p && !stop_p) |=> (cnt == $past(cnt) - 1'b1));

    // R5: a counted edge at zero reloads
    assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && edge_p && cnt == '0 && !start_p && !stop_p) |=> (cnt == $past(reload) && irq));

endmodule

bind chdiv_top chdiv_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .cnt     (cnt_w),
    .reload  (reload_w),
    .tout    (tout),
    .irq     (irq),
    .edge_p  (edge_w),
    .start_p (start_w),
    .stop_p  (stop_w)
);

// File: tb/chdiv_top_tb_top.sv
`timescale 1ns/1ps
module chdiv_top_tb_top;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_in = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic          tout;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_seen = 0;
    bit done     = 0;

    // model state
    logic [CW-1:0] m_cnt = '0;
    logic [CW-1:0] m_reload = '0;
    logic          m_run = 1'b0;
    logic          m_tout = 1'b0;
    logic [1:0]    m_sel = 2'b00;
    logic          m_mode = 1'b0;
    int            m_irqs = 0;

    always #2.5 clk = ~clk;

    chdiv_top dut_i (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tout(tout), .irq(irq)
    );

    always @(posedge clk) if (rst_n && irq) irq_seen++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [CW-1:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic counts(input logic [1:0] sel, input logic rising);
        return (sel == 2'b11) || (sel == 2'b01 && rising) || (sel == 2'b10 && !rising);
    endfunction

    task automatic check_all(input string tag);
        logic [CW-1:0] v;
        rd(2'd3, v); chk({tag, " count"}, v, m_cnt);
        rd(2'd2, v); chk({tag, " status"}, v, {15'd0, m_run});
        @(negedge clk);
        chk({tag, " tout"}, tout, m_tout);
        chk({tag, " irq count"}, irq_seen, m_irqs);
    endtask

    task automatic do_reload(input logic [CW-1:0] v);
        wr(2'd1, v);
        m_reload = v;
    endtask

    task automatic do_ctrl(input logic st, input logic sp, input logic md, input logic [1:0] sel);
        wr(2'd0, {11'd0, sel, md, sp, st});
        m_sel = sel; m_mode = md;
        if (sp) m_run = 1'b0;
        else if (st) begin
            m_run = 1'b1; m_cnt = m_reload;
            if (md) begin m_tout = ~m_tout; m_irqs++; end
        end
    endtask

    task automatic do_toggle();
        logic rising;
        @(negedge clk);
        ext_in = ~ext_in;
        rising = ext_in;
        if (m_run && counts(m_sel, rising)) begin
            if (m_cnt == '0) begin m_cnt = m_reload; m_tout = ~m_tout; m_irqs++; end
            else m_cnt = m_cnt - 1'b1;
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [CW-1:0] v;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_all("R1 reset");
        chk("R1 irq low", irq, 1'b0);

        // R2 start, R7 readable
        do_reload(16'd3);
        do_ctrl(1, 0, 0, 2'b01);
        check_all("R2 start");
        rd(2'd0, v); chk("R2 trigger bits read 0", v[1:0], 2'b00);

        // R4 rising only, R5 wrap, R10 period N+1
        for (int i = 0; i < 3; i++) begin do_toggle(); do_toggle(); end
        check_all("R4 three rising edges");
        chk("R10 no toggle before N+1 edges", tout, 1'b0);
        do_toggle(); do_toggle();
        check_all("R5 wrap");
        chk("R10 toggled after N+1 edges", tout, 1'b1);

        // R6 reload write mid-count
        do_toggle(); do_toggle();
        do_reload(16'd5);
        check_all("R6 reload write no direct effect");
        for (int i = 0; i < 3; i++) begin do_toggle(); do_toggle(); end
        check_all("R6 new reload used at wrap");

        // R8 stop and hold, R7 read while stopped
        do_ctrl(0, 1, 0, 2'b11);
        for (int i = 0; i < 4; i++) do_toggle();
        check_all("R8 stopped hold");
        check_all("R7 read while stopped");

        // R9 start and stop together
        do_ctrl(1, 1, 1, 2'b11);
        check_all("R9 stop wins");

        // R3 start interrupt mode
        do_ctrl(1, 0, 1, 2'b11);
        check_all("R3 start irq");

        // R4 both edges, R11 restart
        do_toggle(); do_toggle();
        check_all("R4 both edges");
        do_ctrl(1, 0, 0, 2'b10);
        check_all("R11 restart");
        do_toggle(); do_toggle();
        check_all("R4 falling only");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 60) do_toggle();
            else if (r < 72) do_reload(($urandom_range(0, 9) == 0) ? 16'($urandom) : 16'($urandom_range(0, 4)));
            else if (r < 84) do_ctrl(1, 0, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
            else if (r < 92) do_ctrl(0, 1, m_mode, m_sel);
            else if (r < 96) do_ctrl(1, 1, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
            else do_ctrl(0, 0, m_mode, 2'($urandom_range(0, 3)));
            if (it % 8 == 7) check_all("R10 random mix");
        end
        check_all("R5 random final");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule